// File: doc/BRIEF.md
# Four-Stream Index Group Transposer

This block is the entry stage of a four-lane pipelined FFT. Up to four independent complex sample streams arrive in parallel, one stream per lane, in natural index order with one sample per lane per clock. The block transposes every four-cycle block of this input. Afterwards each output lane carries one FFT index, and the four streams of that index follow one another on the lane in consecutive cycles. Such a four-cycle slot is a group. Downstream butterflies then treat every stream the same way, one after another.

The transpose uses three parts. Lane s is first delayed by s cycles. A per-lane multiplexer then picks one of the skewed lanes. Lane p is finally delayed by 3 - p cycles. The delay storage is 12 complex words in total, and no frame buffer is used. A frame has 128 or 64 input cycles. The frame length and the number of active streams are both taken from the first input cycle of the frame. A stream that is not active is carried as zeros with the valid strobe low.

Top module: `mstream_group_reorder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state. From the next cycle on, `out_valid`, `out_sof` and `out_eof` are 0, and `out_stream`, `out_re` and `out_im` are all zero.
- R2: A frame is split into blocks of four input cycles. Input cycle k*4+p of a frame is referred to by frame position n = 4k+p. Output cycle k*4+s of the frame carries, on lane p, stream s's sample at frame position 4k+p. Lane p occupies bits [p*12 +: 12] of `in_re`, `in_im`, `out_re` and `out_im`.
- R3: Input cycle u of a frame is matched by output cycle u+3. In that output cycle, `out_stream` equals u mod 4.
- R4: When `pt_long` is 1 at the start of a frame, the frame has 128 input cycles, which is 32 group slots per lane. When it is 0, the frame has 64 input cycles, which is 16 slots.
- R5: `pt_long` is used only in the first valid cycle of a frame. Changing it during the frame has no effect on the frame's length.
- R6: `stream_cnt` holds the number of active streams minus one. With value v, streams 0 to v are active. The value is used only in the first valid cycle of a frame, and changes during the frame have no effect.
- R7: An output cycle that belongs to an inactive stream, or to no frame, has `out_valid` low and all lanes zero.
- R8: `out_sof` is high in the output cycle that matches frame position 0. `out_eof` is high in the output cycle that matches the frame's last position. Both are independent of stream activity.
- R9: Frames may follow each other with no gap or with any idle gap. The input cycles of one frame must be contiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input lanes carry a frame sample this cycle |
| pt_long | input | 1 | 1 selects 128-point frames, 0 selects 64-point frames |
| stream_cnt | input | 2 | Number of active streams minus one |
| in_re | input | 48 | Real parts, lane p at [p*12 +: 12] |
| in_im | input | 48 | Imaginary parts, lane p at [p*12 +: 12] |
| out_valid | output | 1 | The output group member is from an active stream |
| out_sof | output | 1 | First output cycle of a frame |
| out_eof | output | 1 | Last output cycle of a frame |
| out_stream | output | 2 | Stream carried by all lanes this cycle |
| out_re | output | 48 | Real parts of the grouped samples |
| out_im | output | 48 | Imaginary parts of the grouped samples |

## Verification
The bench builds the block with its default parameters: 12-bit components and frame lengths of 128 and 64. Both frame sizes therefore occur, each as a single frame and back to back with the other size. Every stream count from one to four is also covered. Every sample carries a value coded from its frame, stream and position, so any lane or cycle that is swapped shows up directly. The bench drives the mode and count inputs with inverted values inside each frame. This exposes any sampling of those inputs outside the frame boundary.

// File: rtl/grp_reorder_pkg.sv
// Shared constants and the timing tag that travels alongside the data.
// Assumes exactly four lanes; the phase width follows from that.
package grp_reorder_pkg;
    localparam int LANE_N = 4;
    localparam int PH_W   = $clog2(LANE_N);

    // Per-cycle control tag carried through the transpose latency.
    typedef struct packed {
        logic            valid;
        logic            sof;
        logic            eof;
        logic [PH_W-1:0] ph;
        logic [PH_W-1:0] act;
    } tag_t;
endpackage

// File: rtl/grp_delay_line.sv
// Fixed shift-register delay of DEPTH cycles (DEPTH >= 1).
// Assumes the data advances every clock, gated by nothing.
module grp_delay_line #(
    parameter int W     = 24,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] sr [DEPTH];

    // Shift one stage per clock; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
    end

    assign dout = sr[DEPTH-1];
endmodule

// File: rtl/grp_frame_ctl.sv
// Frame position counter, boundary latch for size and stream count,
// and the tag pipeline giving each switch lane its delayed phase.
// Assumes the input cycles of a frame are contiguous.
module grp_frame_ctl
    import grp_reorder_pkg::*;
#(
    parameter int PTS_LONG  = 128,
    parameter int PTS_SHORT = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        pt_long,
    input  logic [PH_W-1:0]             stream_cnt,
    output logic [PH_W-1:0]             act_now,
    output logic [LANE_N-1:0][PH_W-1:0] sw_sel,
    output tag_t                        out_tag
);
    localparam int CNT_W = $clog2(PTS_LONG);
    localparam logic [CNT_W-1:0] LAST_L = CNT_W'(PTS_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(PTS_SHORT - 1);

    logic [CNT_W-1:0] cnt;
    logic             long_q;
    logic [PH_W-1:0]  act_q;
    logic             first, long_eff, at_last;
    tag_t             now_tag;
    tag_t             stg [1:LANE_N-1];

    // Frame settings: live inputs at position 0, latched values afterwards.
    always_comb begin
        first    = (cnt == '0);
        long_eff = first ? pt_long : long_q;
        act_now  = first ? stream_cnt : act_q;
        at_last  = (cnt == (long_eff ? LAST_L : LAST_S));
        now_tag  = '{valid: in_valid, sof: in_valid & first,
                     eof: in_valid & at_last, ph: cnt[PH_W-1:0], act: act_now};
    end

    // Position counter with wrap at the frame end and boundary latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            long_q <= 1'b1;
            act_q  <= '0;
        end else if (in_valid) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
            if (first) begin
                long_q <= pt_long;
                act_q  <= stream_cnt;
            end
        end
    end

    // Tag pipeline, one stage per cycle of transpose latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < LANE_N; i++) stg[i] <= '0;
        end else begin
            stg[1] <= now_tag;
            for (int i = 2; i < LANE_N; i++) stg[i] <= stg[i-1];
        end
    end

    genvar p;
    generate
        for (p = 0; p < LANE_N; p++) begin : g_sel
            if (p == 0) begin : g_live
                assign sw_sel[p] = now_tag.ph;
            end else begin : g_dly
                assign sw_sel[p] = stg[p].ph;
            end
        end
    endgenerate

    assign out_tag = stg[LANE_N-1];
endmodule

// File: rtl/grp_lane_switch.sv
// Crossbar: output lane p takes skewed lane sel[p].
// Assumes sel is already aligned to the skew of lane p.
module grp_lane_switch
    import grp_reorder_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [LANE_N-1:0][W-1:0]    din,
    input  logic [LANE_N-1:0][PH_W-1:0] sel,
    output logic [LANE_N-1:0][W-1:0]    dout
);
    // One multiplexer per output lane.
    always_comb begin
        for (int p = 0; p < LANE_N; p++) dout[p] = din[sel[p]];
    end
endmodule

// File: rtl/mstream_group_reorder.sv
// Transposes four parallel streams into same-index groups by
// skew (lane s delayed s), switch, de-skew (lane p delayed 3-p).
// Latency is three cycles; frames of 128 or 64 contiguous cycles.
module mstream_group_reorder
    import grp_reorder_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int PTS_LONG  = 128,
    parameter int PTS_SHORT = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     pt_long,
    input  logic [PH_W-1:0]          stream_cnt,
    input  logic [LANE_N*DATA_W-1:0] in_re,
    input  logic [LANE_N*DATA_W-1:0] in_im,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic                     out_eof,
    output logic [PH_W-1:0]          out_stream,
    output logic [LANE_N*DATA_W-1:0] out_re,
    output logic [LANE_N*DATA_W-1:0] out_im
);
    localparam int CW = 2 * DATA_W;

    logic [LANE_N-1:0][CW-1:0]   lane_in, skewed, switched, aligned;
    logic [PH_W-1:0]             act_now;
    logic [LANE_N-1:0][PH_W-1:0] sw_sel;
    tag_t                        otag;
    logic                        grp_active;

    grp_frame_ctl #(.PTS_LONG(PTS_LONG), .PTS_SHORT(PTS_SHORT)) u_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pt_long(pt_long),
        .stream_cnt(stream_cnt), .act_now(act_now), .sw_sel(sw_sel),
        .out_tag(otag)
    );

    genvar s;
    generate
        for (s = 0; s < LANE_N; s++) begin : g_skew
            // Inactive streams and idle cycles enter as zeros.
            assign lane_in[s] = (in_valid && (PH_W'(s) <= act_now)) ?
                {in_re[s*DATA_W +: DATA_W], in_im[s*DATA_W +: DATA_W]} : '0;
            if (s == 0) begin : g_direct
                assign skewed[s] = lane_in[s];
            end else begin : g_line
                grp_delay_line #(.W(CW), .DEPTH(s)) u_dl (
                    .clk(clk), .rst_n(rst_n), .din(lane_in[s]), .dout(skewed[s])
                );
            end
        end
    endgenerate

    grp_lane_switch #(.W(CW)) u_sw (.din(skewed), .sel(sw_sel), .dout(switched));

    generate
        for (s = 0; s < LANE_N; s++) begin : g_deskew
            if (s == LANE_N - 1) begin : g_direct
                assign aligned[s] = switched[s];
            end else begin : g_line
                grp_delay_line #(.W(CW), .DEPTH(LANE_N - 1 - s)) u_dl (
                    .clk(clk), .rst_n(rst_n), .din(switched[s]), .dout(aligned[s])
                );
            end
        end
    endgenerate

    // Output qualification: stream must be active in its frame.
    always_comb begin
        grp_active = otag.valid && (otag.ph <= otag.act);
        out_valid  = grp_active;
        out_sof    = otag.sof;
        out_eof    = otag.eof;
        out_stream = otag.valid ? otag.ph : '0;
        for (int p = 0; p < LANE_N; p++) begin
            out_re[p*DATA_W +: DATA_W] = grp_active ? aligned[p][CW-1:DATA_W] : '0;
            out_im[p*DATA_W +: DATA_W] = grp_active ? aligned[p][DATA_W-1:0]  : '0;
        end
    end
endmodule

// File: rtl/mstream_group_reorder_chk.sv
// Port-level temporal checks, attached to every instance by bind.
module mstream_group_reorder_chk
    import grp_reorder_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic                     out_sof,
    input logic                     out_eof,
    input logic [PH_W-1:0]          out_stream,
    input logic [LANE_N*DATA_W-1:0] out_re,
    input logic [LANE_N*DATA_W-1:0] out_im
);
    AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_re == '0 && out_im == '0)); // R7

    AST_SOF_STREAM0: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_stream == '0)); // R8

    AST_EOF_LAST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_stream == PH_W'(LANE_N - 1))); // R8

    AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof && out_stream != '0) |->
        ($past(out_stream) == out_stream - 1'b1)); // R2
endmodule

bind mstream_group_reorder mstream_group_reorder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof), .out_stream(out_stream),
    .out_re(out_re), .out_im(out_im)
);

// File: tb/mstream_group_reorder_tb_top.sv
module mstream_group_reorder_tb_top;
    localparam int DW = 12;
    localparam int HN = 4096;

    // Frame table: {pt_long[7], stream_cnt[6:5], unused[4], gap[3:0]}
    localparam logic [7:0] TBL [8] = '{
        8'b1_11_0_0000, 8'b0_11_0_0010, 8'b0_00_0_0000, 8'b1_01_0_0001,
        8'b0_10_0_0101, 8'b1_11_0_0000, 8'b0_01_0_0000, 8'b1_10_0_0011
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, pt_long;
    logic [1:0]    stream_cnt;
    logic [4*DW-1:0] in_re, in_im;
    logic          out_valid, out_sof, out_eof;
    logic [1:0]    out_stream;
    logic [4*DW-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit h_v [HN];
    int h_pos [HN], h_f [HN], h_act [HN], h_len [HN];

    always #2 clk = ~clk;

    mstream_group_reorder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pt_long(pt_long),
        .stream_cnt(stream_cnt), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_stream(out_stream), .out_re(out_re), .out_im(out_im)
    );

    function automatic logic [DW-1:0] pat_re(int f, int s, int n);
        return DW'(f * 389 + s * 1031 + n * 7 + 3);
    endfunction
    function automatic logic [DW-1:0] pat_im(int f, int s, int n);
        return DW'(f * 53 + s * 211 + n * 97 + 5);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare outputs with the input recorded three cycles earlier (R3).
    task automatic check_out();
        int idx = cyc - 3;
        bit tv = (idx >= 0) && h_v[idx];
        int pos = tv ? h_pos[idx] : 0;
        int s = pos % 4;
        bit ev = tv && (s <= h_act[idx]);
        chk(ev ? "R3" : "R7", "out_valid", int'(out_valid), int'(ev));
        chk("R3", "out_stream", int'(out_stream), tv ? s : 0);
        chk("R8", "out_sof", int'(out_sof), int'(tv && pos == 0));
        chk("R4", "out_eof", int'(out_eof), int'(tv && pos == h_len[idx] - 1));
        for (int p = 0; p < 4; p++) begin
            int n = pos - s + p;
            chk(ev ? "R2" : "R7", $sformatf("re lane%0d", p), int'(out_re[p*DW +: DW]),
                ev ? int'(pat_re(h_f[idx], s, n)) : 0);
            chk(ev ? "R2" : "R7", $sformatf("im lane%0d", p), int'(out_im[p*DW +: DW]),
                ev ? int'(pat_im(h_f[idx], s, n)) : 0);
        end
    endtask

    // One clock: drive at the falling edge, check, record history.
    task automatic step(input bit rv, input bit v, input bit ptv, input logic [1:0] cv,
                        input int f, input int pos, input int act, input int len);
        @(negedge clk);
        rst_n = rv; in_valid = v; pt_long = ptv; stream_cnt = cv;
        for (int s = 0; s < 4; s++) begin
            in_re[s*DW +: DW] = pat_re(f, s, pos);
            in_im[s*DW +: DW] = pat_im(f, s, pos);
        end
        h_v[cyc] = v && rv; h_pos[cyc] = pos; h_f[cyc] = f;
        h_act[cyc] = act; h_len[cyc] = len;
        if (!rv) begin
            if (cyc >= 1) h_v[cyc-1] = 1'b0;
            if (cyc >= 2) h_v[cyc-2] = 1'b0;
        end
        #1;
        check_out();
        cyc++;
    endtask

    task automatic chk_quiet();
        chk("R1", "valid/sof/eof", int'({out_valid, out_sof, out_eof}), 0);
        chk("R1", "out_stream", int'(out_stream), 0);
        chk("R1", "out_re", int'(out_re != '0), 0);
        chk("R1", "out_im", int'(out_im != '0), 0);
    endtask

    task automatic run_frame(input int f, input bit lg, input int act);
        int len = lg ? 128 : 64;
        for (int pos = 0; pos < len; pos++) begin
            // R5 R6: inverted settings inside the frame must be ignored
            step(1'b1, 1'b1, (pos == 0) ? lg : ~lg,
                 (pos == 0) ? 2'(act) : ~2'(act), f, pos, act, len);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fr = 0;
        rst_n = 1'b0; in_valid = 1'b0; pt_long = 1'b0; stream_cnt = '0;
        in_re = '0; in_im = '0;
        for (int i = 0; i < HN; i++) h_v[i] = 1'b0;

        repeat (3) step(1'b0, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);
        chk_quiet(); // R1 after power-up reset
        repeat (2) step(1'b1, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);

        // R9: table of frames with and without idle gaps between them
        for (int e = 0; e < 8; e++) begin
            bit lg = TBL[e][7];
            int act = int'(TBL[e][6:5]);
            int gap = int'(TBL[e][3:0]);
            run_frame(fr, lg, act);
            for (int g = 0; g < gap; g++)
                step(1'b1, 1'b0, ~lg, 2'd3, fr + 50, g, 0, 64);
            fr++;
        end
        repeat (5) step(1'b1, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);

        // R1: reset in the middle of a long frame, then a fresh frame
        for (int pos = 0; pos < 20; pos++)
            step(1'b1, 1'b1, pos == 0, 2'd3, fr, pos, 3, 128);
        step(1'b0, 1'b1, 1'b1, 2'd3, fr, 20, 3, 128);
        step(1'b0, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);
        chk_quiet();
        fr++;
        step(1'b1, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);
        run_frame(fr, 1'b0, 3);
        fr++;
        run_frame(fr, 1'b0, 2);
        repeat (6) step(1'b1, 1'b0, 1'b0, 2'd0, 0, 0, 0, 64);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule